// File: doc/BRIEF.md
# Selectable Periodic Sync Pulse Generator

This block emits a periodic single-cycle synchronization pulse. The pulse comes from one of two kinds of source. The first is an internal down-period counter that is programmed with a cycle count. The second is one of six asynchronous external time-marker inputs, where each rising edge is forwarded as one pulse. A level request starts and stops the generator, and `running_o` reports whether it is actually running.

The actual state only moves at points where it is safe to do so. On the internal source, a stop waits for the current period to finish. The source choice is latched while the generator is idle and is then held for the whole run. A soft reset drains the generator instead of cutting it short, so a downstream consumer never sees a shortened period.

The reset input is asynchronous and active-low. Its release is synchronized inside the block.

Top module: `sync_pulse_gen`

## Requirements
- R1: After reset, `running_o` and `pulse_o` are both 0.
- R2: Select 0 means internal source. If the generator is idle, `run_req_i`=1 and `period_i`=P≥1, then `running_o` goes high in the next cycle. `pulse_o` goes high for one cycle exactly P cycles after `running_o` rose, and again every P cycles after that.
- R3: With select 0 and `period_i`=0, the request is refused and `running_o` stays 0.
- R4: Select k in 1..6 forwards `marker_i[k-1]`. A low-to-high change on that bit gives `pulse_o`=1 for exactly one cycle. That cycle starts two cycles after the clock edge that first samples the marker high. The other marker bits cause no pulse, and select 7 forwards nothing.
- R5: The select is captured only while idle. Changes to `src_sel_i` during a run have no effect on which source drives `pulse_o`.
- R6: On the internal source, dropping the request keeps `running_o` high until the current period completes. `running_o` falls in the same cycle that `pulse_o` carries the final pulse.
- R7: On an external source, dropping the request clears `running_o` in the next cycle.
- R8: A new nonzero `period_i` is taken at the next period boundary and never shortens the period in progress. A zero `period_i` seen at a boundary leaves the old period in use.
- R9: On the internal source, a one-cycle `soft_rst_i` during a run acts as a stop at the next boundary, and the count is not restarted. On an external source it stops the run in the next cycle. It also clears the marker synchronizers. Once the generator is idle, a held request restarts it in the following cycle.
- R10: `pulse_o` is never 1 in a cycle that follows a cycle with `running_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| soft_rst_i | input | 1 | Synchronous soft reset: drains the run and keeps the period and counter |
| run_req_i | input | 1 | Level request: 1 = run, 0 = stop |
| src_sel_i | input | 3 | Source select: 0 = internal counter, 1..6 = marker 1..6 |
| period_i | input | 28 | Internal period in clock cycles |
| marker_i | input | 6 | Asynchronous external time markers |
| pulse_o | output | 1 | Single-cycle synchronization pulse |
| running_o | output | 1 | Actual run state |

## Verification
The assertions assume the following about the inputs:
- `period_i` only reaches the counter at start and at a boundary, so the count always stays below the period in use.
- Marker edges pass through the synchronizer, so two rising edges on one marker cannot land in adjacent cycles.

The stimulus stays within these assumptions:
- Random periods are kept between 0 and 9, so many boundaries, starts and stops fit in a short run.
- Markers toggle at random but only after the falling clock edge.
- Soft resets are rare single-cycle events.
- Selects stay in the range 0..6.

// File: rtl/spg_pkg.sv
package spg_pkg;

  typedef enum logic [1:0] {
    SPG_IDLE  = 2'd0,
    SPG_RUN   = 2'd1,
    SPG_DRAIN = 2'd2
  } spg_state_e;

  localparam int unsigned SPG_SYNC_STAGES = 3;

endpackage

// File: rtl/spg_marker_sync.sv
module spg_marker_sync #(
  parameter int unsigned N_MARK = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [N_MARK-1:0] mark_i,
  output logic [N_MARK-1:0] rise_o
);

  localparam int unsigned STG = spg_pkg::SPG_SYNC_STAGES;

  for (genvar g = 0; g < N_MARK; g++) begin : g_ch
    logic [STG-1:0] sh_q;
    logic [STG-1:0] sh_n;

    always_comb begin
      if (clr_i) sh_n = '0;
      else       sh_n = {sh_q[STG-2:0], mark_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_n;
    end

    // two flops resolve metastability, third one delays for edge detection
    assign rise_o[g] = sh_q[STG-2] & ~sh_q[STG-1];
  end

endmodule

// File: rtl/spg_period_ctr.sv
module spg_period_ctr #(
  parameter int unsigned PERIOD_W = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                en_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                wrap_o
);

  logic [PERIOD_W-1:0] cnt_q, cnt_n;
  logic [PERIOD_W-1:0] per_q, per_n;
  logic                upd;

  assign wrap_o = en_i && (cnt_q == per_q - 1'b1);
  assign upd    = load_i | en_i;

  always_comb begin
    cnt_n = cnt_q;
    per_n = per_q;
    if (load_i) begin
      cnt_n = '0;
      per_n = period_i;
    end else if (en_i) begin
      if (wrap_o) begin
        cnt_n = '0;
        if (period_i != '0) per_n = period_i;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (upd) begin
      cnt_q <= cnt_n;
      per_q <= per_n;
    end
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (per_q != '0) && (cnt_q < per_q));

endmodule

// File: rtl/spg_ctrl.sv
module spg_ctrl #(
  parameter int unsigned N_MARK = 6,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic              run_req_i,
  input  logic [SEL_W-1:0]  src_sel_i,
  input  logic              period_zero_i,
  input  logic              wrap_i,
  input  logic [N_MARK-1:0] rise_i,
  output logic              load_o,
  output logic              cnt_en_o,
  output logic              running_o,
  output logic              pulse_o
);

  import spg_pkg::*;

  spg_state_e       state_q, state_n;
  logic [SEL_W-1:0] src_q, src_n;
  logic             pulse_q, pulse_n;
  logic             int_src;
  logic             stop_ok;
  logic             rise_sel;

  assign int_src   = (src_q == '0);
  assign running_o = (state_q != SPG_IDLE);
  assign cnt_en_o  = running_o && int_src;
  assign stop_ok   = int_src ? wrap_i : 1'b1;
  assign pulse_o   = pulse_q;

  always_comb begin
    rise_sel = 1'b0;
    for (int i = 1; i <= N_MARK; i++) begin
      if (src_q == SEL_W'(i)) rise_sel = rise_i[i-1];
    end
  end

  always_comb begin
    state_n = state_q;
    src_n   = src_q;
    load_o  = 1'b0;
    pulse_n = running_o && (int_src ? wrap_i : rise_sel);
    case (state_q)
      SPG_IDLE: begin
        src_n = src_sel_i;
        if (run_req_i && !soft_rst_i && (src_sel_i != '0 || !period_zero_i)) begin
          state_n = SPG_RUN;
          load_o  = (src_sel_i == '0);
        end
      end
      SPG_RUN: begin
        if (soft_rst_i)      state_n = stop_ok ? SPG_IDLE : SPG_DRAIN;
        else if (!run_req_i && stop_ok) state_n = SPG_IDLE;
      end
      SPG_DRAIN: begin
        if (stop_ok) state_n = SPG_IDLE;
      end
      default: state_n = SPG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SPG_IDLE;
      src_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_n;
      src_q   <= src_n;
      pulse_q <= pulse_n;
    end
  end

  // R5
  src_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |=> $stable(src_q));

  // R6
  stop_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(running_o) && int_src) |-> pulse_q);

  // R3
  zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && src_sel_i == '0 && period_zero_i) |=> !running_o);

  // R4
  ext_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && !int_src) |=> !pulse_q);

endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen #(
  parameter int unsigned PERIOD_W = 28,
  parameter int unsigned N_MARK   = 6,
  parameter int unsigned SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst_i,
  input  logic                run_req_i,
  input  logic [SEL_W-1:0]    src_sel_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [N_MARK-1:0]   marker_i,
  output logic                pulse_o,
  output logic                running_o
);

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [N_MARK-1:0] rise;
  logic              wrap;
  logic              load;
  logic              cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  spg_marker_sync #(.N_MARK(N_MARK)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (soft_rst_i),
    .mark_i (marker_i),
    .rise_o (rise)
  );

  spg_period_ctr #(.PERIOD_W(PERIOD_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_i   (load),
    .en_i     (cnt_en),
    .period_i (period_i),
    .wrap_o   (wrap)
  );

  spg_ctrl #(.N_MARK(N_MARK), .SEL_W(SEL_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .soft_rst_i    (soft_rst_i),
    .run_req_i     (run_req_i),
    .src_sel_i     (src_sel_i),
    .period_zero_i (period_i == '0),
    .wrap_i        (wrap),
    .rise_i        (rise),
    .load_o        (load),
    .cnt_en_o      (cnt_en),
    .running_o     (running_o),
    .pulse_o       (pulse_o)
  );

  // R10
  no_idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !running_o |=> !pulse_o);

endmodule

// File: tb/sync_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module sync_pulse_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_rst;
  logic        run_req;
  logic [2:0]  src_sel;
  logic [27:0] period;
  logic [5:0]  marker;
  logic        pulse;
  logic        running;

  int vectors = 0;
  int errs    = 0;
  int cyc     = 0;

  always #4 clk = ~clk;

  sync_pulse_gen dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst_i (soft_rst),
    .run_req_i  (run_req),
    .src_sel_i  (src_sel),
    .period_i   (period),
    .marker_i   (marker),
    .pulse_o    (pulse),
    .running_o  (running)
  );

  // reference model built from the requirements
  logic [5:0]  m_s1, m_s2, m_s3;
  logic        m_run, m_pend, m_pulse;
  logic [2:0]  m_src;
  logic [27:0] m_cnt, m_per;

  always @(posedge clk or negedge rst_n) begin : mdl
    logic stp;
    logic [5:0] rs;
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_s3 <= '0;
      m_run <= 1'b0; m_pend <= 1'b0; m_pulse <= 1'b0;
      m_src <= '0; m_cnt <= '0; m_per <= '0;
    end else begin
      rs = m_s2 & ~m_s3;
      if (soft_rst) begin
        m_s1 <= '0; m_s2 <= '0; m_s3 <= '0;
      end else begin
        m_s1 <= marker; m_s2 <= m_s1; m_s3 <= m_s2;
      end
      if (!m_run) begin
        m_src   <= src_sel;
        m_pend  <= 1'b0;
        m_pulse <= 1'b0;
        if (run_req && !soft_rst && (src_sel != 0 || period != 0)) begin
          m_run <= 1'b1;
          m_cnt <= '0;
          m_per <= period;
        end
      end else begin
        stp = !run_req || soft_rst || m_pend;
        m_pend <= m_pend | soft_rst;
        if (m_src == 0) begin
          if (m_cnt == m_per - 1) begin
            m_pulse <= 1'b1;
            m_cnt   <= '0;
            if (period != 0) m_per <= period;
            if (stp) begin m_run <= 1'b0; m_pend <= 1'b0; end
          end else begin
            m_pulse <= 1'b0;
            m_cnt   <= m_cnt + 1;
          end
        end else begin
          m_pulse <= (m_src >= 1 && m_src <= 6) ? rs[m_src-1] : 1'b0;
          if (stp) begin m_run <= 1'b0; m_pend <= 1'b0; end
        end
      end
    end
  end

  function automatic logic exp_int_pulse(int k, int p);
    return (k > 0) && (k % p == 0);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0b expected=%0b (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errs++;
      $display("FAIL R1 watchdog actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; soft_rst = 1'b0; run_req = 1'b0;
    src_sel = '0; period = '0; marker = '0;
    repeat (5) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R1
    chk("R1 running after reset", running, 1'b0);
    chk("R1 pulse after reset", pulse, 1'b0);

    // R2 internal start with period 5
    period = 28'd5; src_sel = 3'd0; run_req = 1'b1;
    tick();
    chk("R2 running rises", running, 1'b1);
    for (int k = 1; k <= 11; k++) begin
      tick();
      chk("R2 periodic pulse", pulse, exp_int_pulse(k, 5));
    end
    // R6 deferred stop
    run_req = 1'b0;
    for (int k = 12; k <= 16; k++) begin
      tick();
      chk("R6 running until boundary", running, k < 15);
      chk("R6 final pulse", pulse, k == 15);
    end

    // R3 zero period refused
    period = '0; run_req = 1'b1;
    repeat (3) tick();
    chk("R3 zero period refused", running, 1'b0);
    run_req = 1'b0;
    tick();

    // R4 external marker 3 -> bit 2
    src_sel = 3'd3; run_req = 1'b1;
    tick();
    chk("R4 ext start", running, 1'b1);
    marker[0] = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      tick();
      chk("R4 other marker ignored", pulse, 1'b0);
    end
    marker[2] = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      tick();
      chk("R4 selected marker pulse", pulse, k == 3);
    end

    // R5 select frozen during run
    src_sel = 3'd0; period = 28'd4; marker[2] = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      tick();
      chk("R5 no internal pulse", pulse, 1'b0);
    end
    marker[2] = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk("R5 old source still used", pulse, k == 3);
    end

    // R7 external stop
    run_req = 1'b0;
    tick();
    chk("R7 ext stop next cycle", running, 1'b0);
    marker = '0;
    repeat (4) tick();

    // R8 period changes at boundaries
    src_sel = 3'd0; period = 28'd6; run_req = 1'b1;
    tick();
    for (int k = 1; k <= 13; k++) begin
      if (k == 3) period = 28'd3;
      if (k == 8) period = 28'd0;
      tick();
      chk("R8 period update at boundary", pulse, (k == 6) || (k == 9) || (k == 12));
    end
    run_req = 1'b0;
    for (int k = 14; k <= 16; k++) begin
      tick();
      chk("R8 stop after kept period", running, k < 15);
    end

    // R9 soft reset drains without restarting the count
    period = 28'd4; run_req = 1'b1;
    tick();
    for (int k = 1; k <= 9; k++) begin
      if (k == 3) soft_rst = 1'b1;
      if (k == 4) soft_rst = 1'b0;
      tick();
      chk("R9 running", running, k != 4);
      chk("R9 pulse", pulse, (k == 4) || (k == 9));
    end
    run_req = 1'b0;
    repeat (6) tick();
    chk("R9 idle after drain", running, 1'b0);

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 16 == 0) run_req = ~run_req;
      if ($urandom % 32 == 0) src_sel = 3'($urandom % 7);
      if ($urandom % 32 == 0) period = ($urandom % 8 == 0) ? 28'd0 : 28'(1 + $urandom % 9);
      marker = marker ^ 6'($urandom & $urandom);
      soft_rst = ($urandom % 64 == 0);
      tick();
      chk("R10 random pulse", pulse, m_pulse);
      chk("R2 random running", running, m_run);
    end

    summary();
    $finish;
  end

endmodule